// File: doc/BRIEF.md
# Three-Valued Condition Combiner

This block merges two condition values into one under a selected logical operation. Each condition value has three states: unknown, false and true. The rules are deliberately lopsided. Depending on the operation, an unknown operand may pass through to the result, or a defined operand may absorb it. Several operations produce a defined answer only when the first operand holds one specific value.

A predicate-combining stage feeds the block one request per cycle, marked by a valid strobe. One clock later the block returns the combined condition with its own valid strobe. The block only combines values. The condition store, instruction decoding and any gating of execution belong to the surrounding logic.

Top module: `tvl_cond_combiner`

## Requirements
- R1: Operand codes are 0 = unknown, 1 = unknown, 2 = false and 3 = true. An unknown result is always emitted as code 0, and code 1 never appears on the output.
- R2: With op 0 (and), the result is defined only when operand A is true, and it then equals operand B, or unknown if B is unknown. Op 3 (nand) gives the inverse of op 0 wherever op 0 is defined, and unknown elsewhere.
- R3: With op 1 (or), the result is true if either operand is true. It is false if neither is true and at least one is false. It is unknown if both are unknown. Op 4 (nor) gives the inverse of op 1 wherever op 1 is defined, and unknown elsewhere.
- R4: With op 2 (xor), an unknown A gives unknown. A false A passes B through. A true A gives false when B is true, and true when B is false or unknown.
- R5: With op 5 (and-not), a defined B passes through only when A is false. Op 7 (nand-not) gives the inverse of that B in the same case. Every other case of ops 5 and 7 is unknown.
- R6: With op 6 (or-not), a false A gives true. A true A gives true if B is true and false otherwise. An unknown A passes B through. Op 8 (nor-not) gives the inverse of op 6 wherever op 6 is defined, and unknown elsewhere.
- R7: Op codes 9 to 15 always give unknown (code 0).
- R8: The output valid and result appear exactly one clock after an input valid. A synchronous active-low reset clears the valid and sets the result to 0.
- R9: While the input valid is low, the result holds its last value and the output valid is low.
- R10: Operand code 1 behaves exactly like code 0 in every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Request valid |
| in_op | input | 4 | Operation select |
| in_a | input | 2 | First condition operand |
| in_b | input | 2 | Second condition operand |
| out_vld | output | 1 | Result valid, one clock after in_vld |
| out_cc | output | 2 | Combined condition code |

## Verification
A wrong operation decode or a swapped invert flag changes the result code in the very next cycle after the request, so every request is checked one clock later against an independent table. The sweep covers all 256 combinations of operation and operand codes, which exposes any corrupted table entry, including the alias code 1. A faulty output register shows either as a valid strobe that fails to follow the request within one cycle, or as a result that drifts during idle cycles. The bench probes both with idle cycles that carry random operand noise.

// File: rtl/tvl_pkg.sv
// Shared types for the three-valued condition combiner.
// Assumes a 2-bit condition code where bit 1 marks "defined" and bit 0 the level.
package tvl_pkg;

    // Internal three-valued operand: known flag plus logic level.
    typedef struct packed {
        logic known;
        logic level;
    } trit_t;

    // Base evaluation family selected by the decoder.
    typedef enum logic [2:0] {
        BK_AND  = 3'd0,
        BK_OR   = 3'd1,
        BK_XOR  = 3'd2,
        BK_ANDN = 3'd3,
        BK_ORN  = 3'd4,
        BK_NONE = 3'd5
    } base_kind_t;

    // Number of legal operation codes; higher codes are undefined.
    localparam int unsigned NUM_OPS = 9;

    // Convert an external condition code to the internal form.
    function automatic trit_t code_to_trit(input logic [1:0] code);
        trit_t t;
        t.known = code[1];
        t.level = code[1] & code[0];
        return t;
    endfunction

endpackage

// File: rtl/tvl_op_decode.sv
// Operation decoder.
// Maps an operation code to a base evaluation family and an invert flag.
// Assumes codes 0..NUM_OPS-1 are legal; anything else decodes to BK_NONE.
module tvl_op_decode
    import tvl_pkg::*;
#(
    parameter int unsigned OP_W = 4
) (
    input  logic [OP_W-1:0] op,
    output base_kind_t      kind,
    output logic            invert
);

    localparam int unsigned LAST_OP = NUM_OPS - 1;

    // Purpose: pick the family and whether the result is inverted.
    always_comb begin
        kind   = BK_NONE;
        invert = 1'b0;
        if (op <= OP_W'(LAST_OP)) begin
            case (op[3:0])
                4'd0: begin kind = BK_AND;  invert = 1'b0; end
                4'd1: begin kind = BK_OR;   invert = 1'b0; end
                4'd2: begin kind = BK_XOR;  invert = 1'b0; end
                4'd3: begin kind = BK_AND;  invert = 1'b1; end
                4'd4: begin kind = BK_OR;   invert = 1'b1; end
                4'd5: begin kind = BK_ANDN; invert = 1'b0; end
                4'd6: begin kind = BK_ORN;  invert = 1'b0; end
                4'd7: begin kind = BK_ANDN; invert = 1'b1; end
                4'd8: begin kind = BK_ORN;  invert = 1'b1; end
                default: begin kind = BK_NONE; invert = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/tvl_base_eval.sv
// Base three-valued evaluator.
// Computes one of the five non-inverted families on internal trits.
// Assumes operands are already in the known/level form.
module tvl_base_eval
    import tvl_pkg::*;
(
    input  base_kind_t kind,
    input  trit_t      opa,
    input  trit_t      opb,
    output trit_t      res
);

    logic a_true, a_false, b_true;

    // Purpose: name the operand states used below.
    always_comb begin
        a_true  = opa.known & opa.level;
        a_false = opa.known & ~opa.level;
        b_true  = opb.known & opb.level;
    end

    // Purpose: evaluate the selected family with its unknown-propagation rule.
    always_comb begin
        res = '0;
        case (kind)
            BK_AND: begin
                res.known = a_true & opb.known;
                res.level = opb.level;
            end
            BK_OR: begin
                if (a_true || b_true) begin
                    res = '{known: 1'b1, level: 1'b1};
                end else if (opa.known || opb.known) begin
                    res = '{known: 1'b1, level: 1'b0};
                end
            end
            BK_XOR: begin
                if (a_false) begin
                    res = opb;
                end else if (a_true) begin
                    res = '{known: 1'b1, level: ~b_true};
                end
            end
            BK_ANDN: begin
                res.known = a_false & opb.known;
                res.level = opb.level;
            end
            BK_ORN: begin
                if (a_false) begin
                    res = '{known: 1'b1, level: 1'b1};
                end else if (a_true) begin
                    res = '{known: 1'b1, level: b_true};
                end else begin
                    res = opb;
                end
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/tvl_result_shape.sv
// Result shaper.
// Applies the optional inversion and folds every unknown to code 0.
// Assumes the level bit of an unknown trit carries no meaning.
module tvl_result_shape
    import tvl_pkg::*;
(
    input  trit_t       base,
    input  logic        invert,
    output logic [1:0]  code
);

    // Purpose: build the canonical external code.
    always_comb begin
        if (base.known) begin
            code = {1'b1, base.level ^ invert};
        end else begin
            code = 2'b00;
        end
    end

endmodule

// File: rtl/tvl_cond_combiner.sv
// Three-valued condition combiner, top level.
// Decodes the operation, evaluates the base family, shapes the code and
// registers it with a valid strobe one clock after the request.
// Assumes a synchronous active-low reset; the result holds while idle.
module tvl_cond_combiner
    import tvl_pkg::*;
#(
    parameter int unsigned OP_W = 4,
    parameter int unsigned CC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [OP_W-1:0] in_op,
    input  logic [CC_W-1:0] in_a,
    input  logic [CC_W-1:0] in_b,
    output logic            out_vld,
    output logic [CC_W-1:0] out_cc
);

    localparam logic [CC_W-1:0] CC_UNDEF = '0;
    localparam logic [CC_W-1:0] CC_TRUE  = '1;

    base_kind_t  kind;
    logic        invert;
    trit_t       opa, opb, base_res;
    logic [1:0]  shaped;

    // Purpose: convert operand codes to internal trits.
    always_comb begin
        opa = code_to_trit(in_a[1:0]);
        opb = code_to_trit(in_b[1:0]);
    end

    tvl_op_decode #(.OP_W(OP_W)) u_decode (
        .op     (in_op),
        .kind   (kind),
        .invert (invert)
    );

    tvl_base_eval u_eval (
        .kind (kind),
        .opa  (opa),
        .opb  (opb),
        .res  (base_res)
    );

    tvl_result_shape u_shape (
        .base   (base_res),
        .invert (invert),
        .code   (shaped)
    );

    // Purpose: register the result and valid; hold the result when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_cc  <= CC_UNDEF;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_cc <= CC_W'(shaped);
            end
        end
    end

    // R8: valid follows the request by exactly one clock.
    assert_vld_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    assert_vld_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R1: the alias code never leaves the block.
    assert_no_alias_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_cc != CC_W'(1));

    // R7: illegal operation codes give unknown.
    assert_illegal_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op >= OP_W'(NUM_OPS)) |=> out_cc == CC_UNDEF);

    // R3: a true operand A forces or to true.
    assert_or_absorb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_W'(1) && in_a == CC_TRUE) |=> out_cc == CC_TRUE);

    // R2: and is unknown unless operand A is true.
    assert_and_needs_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_W'(0) && in_a != CC_TRUE) |=> out_cc == CC_UNDEF);

    // R4: an unknown operand A makes xor unknown.
    assert_xor_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_W'(2) && !in_a[1]) |=> out_cc == CC_UNDEF);

    // R9: the result holds while no request arrives.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_cc));

endmodule

// File: tb/tvl_cond_combiner_bench.sv
module tvl_cond_combiner_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [3:0] in_op = '0;
    logic [1:0] in_a = '0;
    logic [1:0] in_b = '0;
    logic       out_vld;
    logic [1:0] out_cc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tvl_cond_combiner u_tvl_cond_combiner (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_cc(out_cc)
    );

    // Symbolic states: 0 unknown, 1 false, 2 true.
    function automatic int sym(input logic [1:0] c);
        if (c == 2'd3) return 2;
        if (c == 2'd2) return 1;
        return 0;
    endfunction

    function automatic int inv_sym(input int s);
        if (s == 1) return 2;
        if (s == 2) return 1;
        return 0;
    endfunction

    function automatic int ref_sym(input int op, input int x, input int y);
        int r;
        r = 0;
        case (op)
            0, 3: begin
                if (x == 2) r = y;
                if (op == 3) r = inv_sym(r);
            end
            1, 4: begin
                if (x == 2 || y == 2) r = 2;
                else if (x == 1 || y == 1) r = 1;
                if (op == 4) r = inv_sym(r);
            end
            2: begin
                if (x == 1) r = y;
                else if (x == 2) r = (y == 2) ? 1 : 2;
            end
            5, 7: begin
                if (x == 1) r = y;
                if (op == 7) r = inv_sym(r);
            end
            6, 8: begin
                if (x == 1) r = 2;
                else if (x == 2) r = (y == 2) ? 2 : 1;
                else r = y;
                if (op == 8) r = inv_sym(r);
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] ref_cc(input int op, input logic [1:0] a, input logic [1:0] b);
        int r;
        r = ref_sym(op, sym(a), sym(b));
        if (r == 2) return 2'd3;
        if (r == 1) return 2'd2;
        return 2'd0;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 3: return "R2";
            1, 4: return "R3";
            2:    return "R4";
            5, 7: return "R5";
            6, 8: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One request, checked at the next falling edge, then an idle noisy cycle.
    task automatic txn(input int op, input logic [1:0] a, input logic [1:0] b, input bit idle_probe);
        logic [1:0] exp;
        logic [1:0] held;
        exp = ref_cc(op, a, b);
        @(negedge clk);
        in_vld = 1'b1; in_op = 4'(op); in_a = a; in_b = b;
        @(negedge clk);
        check(req_of(op), $sformatf("op%0d a%0d b%0d", op, a, b), 32'(out_cc), 32'(exp));
        check("R8", "valid after request", 32'(out_vld), 32'd1);
        if (a == 2'd1) begin
            // R10: alias code gives the same as code 0
            check("R10", "alias operand", 32'(out_cc), 32'(ref_cc(op, 2'd0, b)));
        end
        if (exp == 2'd0) check("R1", "unknown encoded as 0", 32'(out_cc), 32'd0);
        in_vld = 1'b0;
        if (idle_probe) begin
            held = out_cc;
            in_op = 4'($urandom_range(0, 15));
            in_a = 2'($urandom_range(0, 3));
            in_b = 2'($urandom_range(0, 3));
            @(negedge clk);
            check("R9", "result held while idle", 32'(out_cc), 32'(held));
            check("R9", "valid low while idle", 32'(out_vld), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_2024));
        // R8: reset clears valid and result even with a request present
        in_vld = 1'b1; in_op = 4'd1; in_a = 2'd3; in_b = 2'd3;
        repeat (3) @(negedge clk);
        check("R8", "reset valid", 32'(out_vld), 32'd0);
        check("R8", "reset result", 32'(out_cc), 32'd0);
        in_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "idle after reset", 32'(out_vld), 32'd0);

        // Exhaustive sweep of all codes
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    txn(op, 2'(a), 2'(b), (b == 3));

        // Random back-to-back requests
        for (int i = 0; i < 1500; i++) begin
            int op;
            logic [1:0] a, b, exp;
            op = $urandom_range(0, 15);
            a = 2'($urandom_range(0, 3));
            b = 2'($urandom_range(0, 3));
            exp = ref_cc(op, a, b);
            @(negedge clk);
            in_vld = 1'b1; in_op = 4'(op); in_a = a; in_b = b;
            @(negedge clk);
            check(req_of(op), "random request", 32'(out_cc), 32'(exp));
            check("R8", "random valid", 32'(out_vld), 32'd1);
            in_vld = ($urandom_range(0, 3) == 0) ? 1'b0 : 1'b1;
            if (!in_vld) begin
                logic [1:0] held;
                held = out_cc;
                @(negedge clk);
                check("R9", "random idle hold", 32'(out_cc), 32'(held));
            end
        end

        // Mid-run reset
        @(negedge clk);
        in_vld = 1'b1; in_op = 4'd1; in_a = 2'd3; in_b = 2'd0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", "mid-run reset valid", 32'(out_vld), 32'd0);
        check("R8", "mid-run reset result", 32'(out_cc), 32'd0);
        in_vld = 1'b0;
        rst_n = 1'b1;
        txn(6, 2'd1, 2'd2, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule